// File: doc/BRIEF.md
# Glitch-Free Oscillator Frequency Switcher

The block picks one clock out of eight candidates and drives it onto a single output clock. A 3-bit frequency code chooses the candidate. Code 0 picks an independent low-frequency source. Codes 1 to 7 pick taps of a power-of-two divider chain that runs from a fast internal oscillator, and the top code gives the undivided oscillator.

The code may change at any moment. When it does, the output is parked low at a falling edge of the clock it is leaving. It is reconnected only after the requested clock has shown eight falling edges, so the output never carries a runt pulse. A central arbiter in the fast-oscillator domain grants at most one source at a time. It issues a new grant only after every source has reported itself idle, so a handover that is overtaken by a newer code is dropped cleanly.

A frequency-stable flag reports settling. When the code moves away from the low-frequency source, the flag clears and a settling timer, counted in fast-oscillator cycles, runs before the flag sets again. Every other code change leaves the flag as it is. The flag is status only and never holds back the output.

Top module: `oscFreqSwitch`

## Requirements
- R1: Code c from 1 to 7 makes the output follow the fast oscillator divided by 2^(7-c), so code 7 is undivided and code 1 divides by 64. Code 0 makes the output follow the low-frequency source.
- R2: During and after an asynchronous reset (rstN low), the output follows the low-frequency source, the flag reads 0, and no handover is pending.
- R3: At most one source is connected at any time. Across a code change, no high or low output pulse is shorter than half the period of the faster of the old and new clocks.
- R4: After a code change the output drops at a falling edge of the old clock and stays low for at least eight periods of the requested clock before it follows that clock.
- R5: A change from code 0 to a nonzero code clears the flag within 6 fast-oscillator cycles of the write. The flag stays clear for at least SETTLE_CYCLES-8 such cycles and is set by SETTLE_CYCLES+8 cycles after the write.
- R6: Any other code change (nonzero to anything, or 0 to 0) leaves the flag unchanged.
- R7: While the flag is clear, the output already runs at the newly requested frequency.
- R8: A code written while a handover is still in progress abandons that handover. The output then settles on the newest code, with no runt pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Fast internal oscillator; it also clocks the arbiter and the settling timer |
| slowClk | input | 1 | Independent low-frequency source, selected by code 0 |
| rstN | input | 1 | Asynchronous active-low reset |
| freqSel | input | 3 | Frequency code, may change at any time |
| clkOut | output | 1 | Selected output clock |
| freqStable | output | 1 | Set when the output frequency has settled |

## Verification
The bench builds the block with SETTLE_CYCLES=800 and EDGE_COUNT=8, a 125 MHz fast oscillator, and a 1 MHz low-frequency source. With this short timer and a slow source only 125 fast cycles per period, all 64 ordered pairs of codes fit in one run, each reached from its partner and back. Every handover is timed for period, pulse widths and hold-low gap, and the flag is tracked by a small arithmetic model. Two extra sequences overtake a handover: one while the old source is still being released, and one while the new source is counting edges.

// File: rtl/clkswPkg.sv
package clkswPkg;
  localparam int SEL_W = 3;
  localparam int LANES = 1 << SEL_W;
  localparam int DIV_W = LANES - 2;

  typedef struct packed {
    logic [LANES-1:0] laneEn;
  } swStrobe_t;
endpackage

// File: rtl/clkswDatapath.sv
module clkswDatapath
  import clkswPkg::*;
(
  input  logic             fastClk,
  input  logic             slowClk,
  input  logic             rstN,
  input  swStrobe_t        strobe,
  output logic [LANES-1:0] candClk,
  output logic             clkOut
);
  logic [DIV_W-1:0] divCnt;

  // ripple-free postscaler: bit k toggles at fastClk/2^(k+1)
  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_cand
      if (i == 0) begin : g_slow
        assign candClk[i] = slowClk;
      end else if (i == LANES - 1) begin : g_fast
        assign candClk[i] = fastClk;
      end else begin : g_tap
        assign candClk[i] = divCnt[LANES-2-i];
      end
    end
  endgenerate

  // enables only move while their own clock is low, so the OR is clean
  assign clkOut = |(candClk & strobe.laneEn);

  assert_one_source_R3: assert property (@(posedge fastClk) disable iff (!rstN)
    $onehot0(strobe.laneEn));
endmodule

// File: rtl/clkswLane.sv
module clkswLane #(
  parameter int EDGE_COUNT = 8,
  parameter bit START_ON   = 1'b0
) (
  input  logic laneClk,
  input  logic rstN,
  input  logic grant,
  output logic busy,
  output logic connect
);
  localparam int CNT_W = $clog2(EDGE_COUNT + 1);

  logic             wantS1;
  logic             wantS2;
  logic [CNT_W-1:0] edgeCnt;

  always_ff @(negedge laneClk or negedge rstN) begin
    if (!rstN) begin
      wantS1  <= START_ON;
      wantS2  <= START_ON;
      edgeCnt <= '0;
      connect <= START_ON;
    end else begin
      wantS1 <= grant;
      wantS2 <= wantS1;
      if (!wantS2) begin
        connect <= 1'b0;
        edgeCnt <= '0;
      end else if (!connect) begin
        if (edgeCnt == CNT_W'(EDGE_COUNT - 1)) connect <= 1'b1;
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  assign busy = wantS2 | connect;

  assert_release_R4: assert property (@(negedge laneClk) disable iff (!rstN)
    !wantS2 |=> !connect);
endmodule

// File: rtl/clkswCtrl.sv
module clkswCtrl
  import clkswPkg::*;
#(
  parameter int SETTLE_CYCLES = 32000,
  parameter int EDGE_COUNT    = 8
) (
  input  logic             fastClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selCode,
  input  logic [LANES-1:0] candClk,
  output swStrobe_t        strobe,
  output logic             freqStable
);
  localparam int TMR_W = $clog2(SETTLE_CYCLES + 1);

  logic [SEL_W-1:0] selS1, selS2, prevSel, curCode;
  logic             grantValid;
  logic [LANES-1:0] laneGrant, laneBusy, busyS1, busyS2, laneConn;
  logic [TMR_W-1:0] timerLeft;
  logic             startSettle;

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      selS1   <= '0;
      selS2   <= '0;
      prevSel <= '0;
      busyS1  <= '0;
      busyS2  <= '0;
    end else begin
      selS1   <= selCode;
      selS2   <= selS1;
      prevSel <= selS2;
      busyS1  <= laneBusy;
      busyS2  <= busyS1;
    end
  end

  // arbiter: drop the grant on any code change, regrant once all lanes idle
  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b1;
      curCode    <= '0;
    end else if (grantValid && (selS2 != curCode)) begin
      grantValid <= 1'b0;
    end else if (!grantValid && (busyS2 == '0)) begin
      curCode    <= selS2;
      grantValid <= 1'b1;
    end
  end

  assign startSettle = (prevSel == '0) && (selS2 != '0);

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      timerLeft  <= '0;
      freqStable <= 1'b0;
    end else if (startSettle) begin
      timerLeft  <= TMR_W'(SETTLE_CYCLES);
      freqStable <= 1'b0;
    end else if (timerLeft != '0) begin
      timerLeft <= timerLeft - 1'b1;
      if (timerLeft == TMR_W'(1)) freqStable <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign laneGrant[i] = grantValid && (curCode == SEL_W'(i));
      clkswLane #(
        .EDGE_COUNT (EDGE_COUNT),
        .START_ON   (i == 0)
      ) u_lane (
        .laneClk (candClk[i]),
        .rstN    (rstN),
        .grant   (laneGrant[i]),
        .busy    (laneBusy[i]),
        .connect (laneConn[i])
      );
    end
  endgenerate

  assign strobe.laneEn = laneConn;

  assert_grant_quiet_R3: assert property (@(posedge fastClk) disable iff (!rstN)
    $rose(grantValid) |-> (strobe.laneEn == '0));
  assert_flag_drop_R5: assert property (@(posedge fastClk) disable iff (!rstN)
    $fell(freqStable) |-> (timerLeft == TMR_W'(SETTLE_CYCLES)));
  assert_flag_rise_R5: assert property (@(posedge fastClk) disable iff (!rstN)
    $rose(freqStable) |-> (timerLeft == '0));
  assert_flag_hold_R6: assert property (@(posedge fastClk) disable iff (!rstN)
    (timerLeft == '0 && !startSettle) |=> $stable(freqStable));
endmodule

// File: rtl/oscFreqSwitch.sv
module oscFreqSwitch #(
  parameter int SETTLE_CYCLES = 32000,
  parameter int EDGE_COUNT    = 8
) (
  input  logic                         fastClk,
  input  logic                         slowClk,
  input  logic                         rstN,
  input  logic [clkswPkg::SEL_W-1:0]   freqSel,
  output logic                         clkOut,
  output logic                         freqStable
);
  clkswPkg::swStrobe_t              strobe;
  logic [clkswPkg::LANES-1:0]       candClk;

  clkswCtrl #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .EDGE_COUNT    (EDGE_COUNT)
  ) u_ctrl (
    .fastClk    (fastClk),
    .rstN       (rstN),
    .selCode    (freqSel),
    .candClk    (candClk),
    .strobe     (strobe),
    .freqStable (freqStable)
  );

  clkswDatapath u_dp (
    .fastClk (fastClk),
    .slowClk (slowClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .candClk (candClk),
    .clkOut  (clkOut)
  );
endmodule

// File: tb/oscFreqSwitch_tb.sv
`timescale 1ns/1ps
module oscFreqSwitch_tb;
  localparam int  SETTLE  = 800;
  localparam real FAST_NS = 8.0;
  localparam real SLOW_NS = 1000.0;

  logic       fastClk = 1'b0;
  logic       slowClk = 1'b0;
  logic       rstN    = 1'b0;
  logic [2:0] freqSel = 3'd0;
  logic       clkOut;
  logic       freqStable;

  int  checks = 0;
  int  miscompares = 0;
  int  cycleCount = 0;
  bit  done = 1'b0;
  int  curTb = 0;
  bit  stableExp = 1'b0;
  real lastRise = 0.0, lastFall = 0.0;
  real minHigh = 1.0e9, minLow = 1.0e9, maxLow = 0.0;
  real wHi, wLo;

  oscFreqSwitch #(.SETTLE_CYCLES(SETTLE), .EDGE_COUNT(8)) u_dut (
    .fastClk(fastClk), .slowClk(slowClk), .rstN(rstN),
    .freqSel(freqSel), .clkOut(clkOut), .freqStable(freqStable)
  );

  always #(FAST_NS/2) fastClk = ~fastClk;
  initial begin
    #1;
    forever #(SLOW_NS/2) slowClk = ~slowClk;
  end

  always @(posedge clkOut) begin
    wLo = $realtime - lastFall;
    if (wLo < minLow) minLow = wLo;
    if (wLo > maxLow) maxLow = wLo;
    lastRise = $realtime;
  end
  always @(negedge clkOut) begin
    wHi = $realtime - lastRise;
    if (wHi < minHigh) minHigh = wHi;
    lastFall = $realtime;
  end

  always @(posedge fastClk) begin
    cycleCount++;
    if (cycleCount > 190000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected below 190000", cycleCount);
      $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
      $finish;
    end
  end

  function automatic real periodOf(input int c);
    return (c == 0) ? SLOW_NS : FAST_NS * real'(1 << (7 - c));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    minHigh = 1.0e9; minLow = 1.0e9; maxLow = 0.0;
  endtask

  task automatic waitUntil(input real t);
    while ($realtime < t) @(negedge fastClk);
  endtask

  task automatic measure(input string req, input real expP, output bit flagAt);
    real t1, t2, d;
    @(posedge clkOut); t1 = $realtime;
    @(posedge clkOut); t2 = $realtime;
    flagAt = freqStable;
    d = t2 - t1;
    chk((d - expP < 0.01) && (expP - d < 0.01), req, "output period", d, expP);
  endtask

  task automatic pulseChk(input string req, input real pA, input real pB);
    real lim;
    lim = ((pA < pB) ? pA : pB) / 2.0 - 0.01;
    chk(minHigh >= lim, req, "shortest high pulse", minHigh, lim);
    chk(minLow >= lim, req, "shortest low pulse", minLow, lim);
  endtask

  task automatic switchTo(input int nc);
    real tW, oldP, newP;
    bit  startS, flagMid;
    oldP   = periodOf(curTb);
    newP   = periodOf(nc);
    startS = (curTb == 0) && (nc != 0);
    @(negedge fastClk);
    tW = $realtime;
    clearMon();
    freqSel = 3'(nc);
    repeat (6) @(negedge fastClk);
    if (startS) begin
      stableExp = 1'b0;
      chk(freqStable == 1'b0, "R5", "flag after leaving code 0", real'(freqStable), 0.0);
    end
    waitUntil(tW + 4.0*oldP + 12.0*newP + 200.0);
    measure("R1", newP, flagMid);
    pulseChk("R3", oldP, newP);
    if (nc != curTb)
      chk(maxLow >= 8.0*newP - 0.01, "R4", "hold-low gap", maxLow, 8.0*newP);
    if (startS) begin
      if ($realtime < tW + real'(SETTLE - 8)*FAST_NS) begin
        chk(flagMid == 1'b0, "R7", "flag while new clock runs", real'(flagMid), 0.0);
        waitUntil(tW + real'(SETTLE - 8)*FAST_NS);
        chk(freqStable == 1'b0, "R5", "flag before timer end", real'(freqStable), 0.0);
      end
      waitUntil(tW + real'(SETTLE + 8)*FAST_NS);
      chk(freqStable == 1'b1, "R5", "flag after timer end", real'(freqStable), 1.0);
      stableExp = 1'b1;
    end else begin
      chk(freqStable == stableExp, "R6", "flag unchanged", real'(freqStable), real'(stableExp));
    end
    curTb = nc;
  endtask

  initial begin
    bit fl;
    real tA;
    #20;
    chk(freqStable == 1'b0, "R2", "flag in reset", real'(freqStable), 0.0);
    measure("R2", SLOW_NS, fl);
    @(negedge fastClk);
    rstN = 1'b1;
    repeat (4) @(negedge fastClk);
    chk(freqStable == 1'b0, "R2", "flag after reset", real'(freqStable), 0.0);
    measure("R2", SLOW_NS, fl);

    // all ordered pairs of codes, each visited from its partner and back
    for (int a = 0; a < 8; a++) begin
      switchTo(a);
      for (int b = 0; b < 8; b++) begin
        switchTo(b);
        switchTo(a);
      end
    end

    // R8: overtake while the low-frequency lane is still being released
    switchTo(0);
    @(negedge fastClk);
    tA = $realtime;
    clearMon();
    freqSel = 3'd7;
    repeat (20) @(negedge fastClk);
    freqSel = 3'd3;
    waitUntil(tA + 4.0*SLOW_NS + 12.0*periodOf(3) + 400.0);
    measure("R8", periodOf(3), fl);
    pulseChk("R8", SLOW_NS, periodOf(3));
    waitUntil(tA + real'(SETTLE + 8)*FAST_NS);
    chk(freqStable == 1'b1, "R8", "flag after overtaken switch", real'(freqStable), 1.0);
    stableExp = 1'b1;
    curTb = 3;

    // R8: overtake while the requested slow tap is counting edges
    switchTo(6);
    @(negedge fastClk);
    tA = $realtime;
    clearMon();
    freqSel = 3'd1;
    waitUntil(tA + 2000.0);
    freqSel = 3'd6;
    waitUntil(tA + 2000.0 + 4.0*periodOf(1) + 12.0*periodOf(6) + 400.0);
    measure("R8", periodOf(6), fl);
    pulseChk("R8", periodOf(6), periodOf(6));
    chk(freqStable == 1'b1, "R8", "flag kept on abandon", real'(freqStable), 1.0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
    $finish;
  end
endmodule